// File: doc/BRIEF.md
# NAND Bus-Width Access Adapter

This block turns register-style CPU accesses of one, two or four bytes into a series of cycles on an 8-bit or 16-bit NAND I/O port. The CPU address space holds a row of chip-select banks. Each bank contains three narrow-access registers: command, address and data. The register that was hit selects the control pins for the device cycles. The command register drives the command-latch pin, the address register drives the address-latch pin, and the data register drives neither. On a read, the data from successive device cycles is packed into one 32-bit word.

Each bank carries two configuration bits from outside the block. One marks the bank as a NAND-type device and the other selects a 16-bit bus. Command, address and data accesses to a bank that is not NAND-type finish at once and do nothing. A sub-word access to any other offset is refused with an error flag.

The control is a three-state machine. In `ST_IDLE` the CPU port is ready. On an accepted request, `ST_IDLE -> ST_XFER` is taken when device cycles are needed, and `ST_IDLE -> ST_DONE` is taken when none are needed. In `ST_XFER` one device cycle is presented at a time. The state stays in `ST_XFER` until the last cycle handshakes, and then `ST_XFER -> ST_DONE` is taken. `ST_DONE` holds the completion pulse for one cycle and always returns `ST_DONE -> ST_IDLE`.

Top module: `nba_adapter`

## Requirements
- R1: On an 8-bit bank, a data, command or address write of size code 0, 1 or 2/3 (1, 2 or 4 bytes) produces 1, 2 or 4 device cycles, least significant byte first. The byte is on dev_wdata[7:0] and the upper bits are zero. A data read produces the same number of cycles.
- R2: On a 16-bit bank, size code 1 produces one device cycle carrying the low halfword. Size code 2 or 3 produces two cycles, low halfword first.
- R3: On a 16-bit bank, a one-byte write is one cycle carrying cpu_wdata[15:0]. A one-byte read is one cycle, and only the low 8 bits of dev_rdata are returned.
- R4: Command writes (bank offsets 0x1C-0x1F) assert dev_cle. Address writes (0x20-0x23) assert dev_ale. Data accesses (0x24-0x27) assert neither, and the two pins are never high together. Reads of the command or address register make no device cycle and return 0.
- R5: A sub-word access (size code 0 or 1) to any offset other than the three narrow registers, inside or outside the banks, completes with cpu_err=1 and makes no device cycle. A 32-bit access to such an offset completes with cpu_err=0, makes no device cycle and returns 0.
- R6: Command, address and data accesses to a bank whose cfg_nand bit is 0 make no device cycle. A read of such a bank returns 0.
- R7: While dev_valid is high and dev_ready is low, every dev_* output stays stable. cpu_done pulses for one cycle, one cycle after the last device handshake. cpu_ready is high only in ST_IDLE, and no device cycle is presented while it is high.
- R8: Read data from successive cycles fills increasing byte lanes (8-bit) or halfword lanes (16-bit) of cpu_rdata. The lanes above the transferred size are zero.
- R9: After reset, cpu_ready=1, dev_valid=0, cpu_done=0 and cpu_rdata=0. A reset during a transfer abandons it.
- R10: Bank b covers addresses BANK_BASE+b*BANK_STRIDE up to, but not including, the start of bank b+1. During that bank's device cycles, dev_cs is one-hot with bit b set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | Block can take a request (ST_IDLE) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address in the register window |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cpu_wdata | input | CPU_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Access refused (valid with cpu_done) |
| cpu_rdata | output | CPU_W | Assembled read data (valid with cpu_done) |
| cfg_nand | input | NUM_BANKS | Bank is a NAND-type device |
| cfg_wide | input | NUM_BANKS | Bank uses a 16-bit device bus |
| dev_valid | output | 1 | Device cycle presented |
| dev_ready | input | 1 | Device takes or returns the cycle |
| dev_we | output | 1 | Device cycle is a write |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_cs | output | NUM_BANKS | One-hot bank select during cycles |
| dev_wdata | output | DEV_W | Device write data |
| dev_rdata | input | DEV_W | Device read data |

## Verification
The bound checker watches these properties on every cycle:
- the device outputs hold while a cycle is stalled;
- the two latch pins are never high together, and neither is high on a read;
- the bank select is one-hot;
- cpu_ready and dev_valid are never high together;
- the completion pulse lasts one cycle;
- refused accesses make no device cycle, and no access makes more than four cycles.

Only the bench scenarios can show that the cycle count matches each size and width pairing, and that bytes and halfwords leave and return in the right lane order. The same holds for sub-word reads from a 16-bit bank being truncated, for the last bank being decoded, and for a reset abandoning a stalled transfer.

// File: rtl/nba_pkg.sv
package nba_pkg;

    typedef enum logic [1:0] {
        REG_CMD,
        REG_ADR,
        REG_DAT,
        REG_OTHER
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE
    } st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/nba_decode.sv
module nba_decode
    import nba_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_BANKS   = 8,
    parameter int BANK_BASE   = 'h060,
    parameter int BANK_STRIDE = 'h030,
    parameter int CMD_OFF     = 'h1C,
    parameter int ADR_OFF     = 'h20,
    parameter int DAT_OFF     = 'h24,
    localparam int BIDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 in_bank,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic [BIDX_W-1:0]    bank_idx,
    output reg_kind_e            kind
);

    reg_kind_e kind_b [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = BANK_BASE + b * BANK_STRIDE;
        logic [31:0] off;
        logic [31:0] word_sel;

        assign off         = 32'(addr) - 32'(LO);
        assign word_sel    = off >> 2;
        assign bank_hit[b] = (32'(addr) >= 32'(LO)) && (off < 32'(BANK_STRIDE));
        assign kind_b[b]   = (word_sel == 32'(CMD_OFF / 4)) ? REG_CMD :
                             (word_sel == 32'(ADR_OFF / 4)) ? REG_ADR :
                             (word_sel == 32'(DAT_OFF / 4)) ? REG_DAT : REG_OTHER;
    end

    always_comb begin
        in_bank  = |bank_hit;
        bank_idx = '0;
        kind     = REG_OTHER;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                bank_idx = BIDX_W'(b);
                kind     = kind_b[b];
            end
        end
    end

endmodule

// File: rtl/nba_lane_mux.sv
module nba_lane_mux
    import nba_pkg::*;
#(
    parameter int CPU_W  = 32,
    parameter int DEV_W  = 16,
    localparam int BEAT_W = $clog2(CPU_W / 8)
) (
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic [BEAT_W-1:0] beat,
    input  logic [CPU_W-1:0]  wdata,
    output logic [DEV_W-1:0]  dev_wdata,
    output logic              last_beat
);

    localparam int NARROW     = DEV_W / 2;
    localparam int WIDE_BEATS = CPU_W / DEV_W;
    localparam int NARR_BEATS = CPU_W / NARROW;

    logic [BEAT_W-1:0] ncyc_m1;

    always_comb begin
        if (wide) begin
            ncyc_m1 = (size == SZ_BYTE || size == SZ_HALF) ? '0 : BEAT_W'(WIDE_BEATS - 1);
        end else begin
            unique case (size)
                SZ_BYTE: ncyc_m1 = '0;
                SZ_HALF: ncyc_m1 = BEAT_W'(1);
                default: ncyc_m1 = BEAT_W'(NARR_BEATS - 1);
            endcase
        end
    end

    assign last_beat = (beat == ncyc_m1);

    always_comb begin
        if (wide) begin
            dev_wdata = wdata[(int'(beat) % WIDE_BEATS) * DEV_W +: DEV_W];
        end else begin
            dev_wdata = DEV_W'(wdata[int'(beat) * NARROW +: NARROW]);
        end
    end

endmodule

// File: rtl/nba_read_merge.sv
module nba_read_merge
    import nba_pkg::*;
#(
    parameter int CPU_W  = 32,
    parameter int DEV_W  = 16,
    localparam int BEAT_W = $clog2(CPU_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic [BEAT_W-1:0] beat,
    input  logic [DEV_W-1:0]  rd,
    output logic [CPU_W-1:0]  merged
);

    localparam int NARROW     = DEV_W / 2;
    localparam int WIDE_BEATS = CPU_W / DEV_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged <= '0;
        end else if (clr) begin
            merged <= '0;
        end else if (load) begin
            if (wide && size == SZ_BYTE) begin
                merged[NARROW-1:0] <= rd[NARROW-1:0];
            end else if (wide) begin
                merged[(int'(beat) % WIDE_BEATS) * DEV_W +: DEV_W] <= rd;
            end else begin
                merged[int'(beat) * NARROW +: NARROW] <= rd[NARROW-1:0];
            end
        end
    end

endmodule

// File: rtl/nba_adapter.sv
module nba_adapter
    import nba_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CPU_W       = 32,
    parameter int DEV_W       = 16,
    parameter int NUM_BANKS   = 8,
    parameter int BANK_BASE   = 'h060,
    parameter int BANK_STRIDE = 'h030,
    parameter int CMD_OFF     = 'h1C,
    parameter int ADR_OFF     = 'h20,
    parameter int DAT_OFF     = 'h24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_valid,
    output logic                 cpu_ready,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [1:0]           cpu_size,
    input  logic [CPU_W-1:0]     cpu_wdata,
    output logic                 cpu_done,
    output logic                 cpu_err,
    output logic [CPU_W-1:0]     cpu_rdata,
    input  logic [NUM_BANKS-1:0] cfg_nand,
    input  logic [NUM_BANKS-1:0] cfg_wide,
    output logic                 dev_valid,
    input  logic                 dev_ready,
    output logic                 dev_we,
    output logic                 dev_cle,
    output logic                 dev_ale,
    output logic [NUM_BANKS-1:0] dev_cs,
    output logic [DEV_W-1:0]     dev_wdata,
    input  logic [DEV_W-1:0]     dev_rdata
);

    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int BEAT_W = $clog2(CPU_W / 8);

    st_e state_q, state_d;

    logic                 in_bank;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [BIDX_W-1:0]    bank_idx;
    reg_kind_e            kind;

    logic                 we_q, wide_q, err_q;
    reg_kind_e            kind_q;
    logic [1:0]           size_q;
    logic [CPU_W-1:0]     wdata_q;
    logic [NUM_BANKS-1:0] cs_q;
    logic [BEAT_W-1:0]    beat_q;

    logic                 accept, legal, needs_dev, hs, last_beat;
    logic [DEV_W-1:0]     lane_wdata;
    logic [CPU_W-1:0]     merged;

    nba_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BASE(BANK_BASE),
        .BANK_STRIDE(BANK_STRIDE), .CMD_OFF(CMD_OFF), .ADR_OFF(ADR_OFF),
        .DAT_OFF(DAT_OFF)
    ) u_decode (
        .addr(cpu_addr), .in_bank(in_bank), .bank_hit(bank_hit),
        .bank_idx(bank_idx), .kind(kind)
    );

    nba_lane_mux #(.CPU_W(CPU_W), .DEV_W(DEV_W)) u_lane (
        .wide(wide_q), .size(size_q), .beat(beat_q), .wdata(wdata_q),
        .dev_wdata(lane_wdata), .last_beat(last_beat)
    );

    nba_read_merge #(.CPU_W(CPU_W), .DEV_W(DEV_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .clr(accept), .load(hs && !we_q),
        .wide(wide_q), .size(size_q), .beat(beat_q), .rd(dev_rdata),
        .merged(merged)
    );

    assign accept    = (state_q == ST_IDLE) && cpu_valid;
    assign legal     = (cpu_size != SZ_BYTE && cpu_size != SZ_HALF)
                     || (in_bank && kind != REG_OTHER);
    assign needs_dev = legal && in_bank && cfg_nand[bank_idx]
                     && (kind == REG_DAT || (cpu_we && kind != REG_OTHER));
    assign hs        = (state_q == ST_XFER) && dev_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = needs_dev ? ST_XFER : ST_DONE;
            ST_XFER: if (hs && last_beat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Access context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
            err_q   <= 1'b0;
            kind_q  <= REG_OTHER;
            size_q  <= '0;
            wdata_q <= '0;
            cs_q    <= '0;
            beat_q  <= '0;
        end else if (accept) begin
            we_q    <= cpu_we;
            wide_q  <= cfg_wide[bank_idx];
            err_q   <= !legal;
            kind_q  <= kind;
            size_q  <= cpu_size;
            wdata_q <= cpu_wdata;
            cs_q    <= bank_hit;
            beat_q  <= '0;
        end else if (hs && !last_beat) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cpu_ready = (state_q == ST_IDLE);
        cpu_done  = (state_q == ST_DONE);
        cpu_err   = (state_q == ST_DONE) && err_q;
        cpu_rdata = merged;
        dev_valid = (state_q == ST_XFER);
        dev_we    = dev_valid && we_q;
        dev_cle   = dev_valid && we_q && (kind_q == REG_CMD);
        dev_ale   = dev_valid && we_q && (kind_q == REG_ADR);
        dev_cs    = dev_valid ? cs_q : '0;
        dev_wdata = (dev_valid && we_q) ? lane_wdata : '0;
    end

endmodule

// File: rtl/nba_adapter_chk.sv
module nba_adapter_chk #(
    parameter int NUM_BANKS = 8,
    parameter int DEV_W     = 16,
    parameter int MAX_BEATS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_valid,
    input logic                 cpu_ready,
    input logic                 cpu_done,
    input logic                 cpu_err,
    input logic                 dev_valid,
    input logic                 dev_ready,
    input logic                 dev_we,
    input logic                 dev_cle,
    input logic                 dev_ale,
    input logic [NUM_BANKS-1:0] dev_cs,
    input logic [DEV_W-1:0]     dev_wdata
);

    localparam int CW = $clog2(MAX_BEATS + 2) + 1;
    logic [CW-1:0] beats_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      beats_seen <= '0;
        else if (cpu_ready && cpu_valid) beats_seen <= '0;
        else if (dev_valid && dev_ready) beats_seen <= beats_seen + 1'b1;
    end

    AST_DEV_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_ready |=> dev_valid && $stable(dev_wdata) && $stable(dev_cle)
            && $stable(dev_ale) && $stable(dev_we) && $stable(dev_cs)); // R7
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_cle && dev_ale)); // R4
    AST_READ_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_we |-> !dev_cle && !dev_ale); // R4
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> $countones(dev_cs) == 1); // R10
    AST_IDLE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !dev_valid); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done && cpu_ready); // R7
    AST_MAX_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> beats_seen <= CW'(MAX_BEATS)); // R1
    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_err |-> beats_seen == '0); // R5

endmodule

bind nba_adapter nba_adapter_chk #(
    .NUM_BANKS(NUM_BANKS), .DEV_W(DEV_W), .MAX_BEATS(CPU_W / 8)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .dev_we(dev_we), .dev_cle(dev_cle),
    .dev_ale(dev_ale), .dev_cs(dev_cs), .dev_wdata(dev_wdata)
);

// File: tb/nba_adapter_tb.sv
module nba_adapter_tb;

    localparam int NB = 8;

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        wide;
        logic [2:0]  ncyc;
        logic        cle;
        logic        ale;
        logic        err;
        logic [31:0] rdata;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h07C, 2'd0, 32'h44332211, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b1, 12'h080, 2'd2, 32'h44332211, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0,        2'd1},
        '{1'b1, 12'h086, 2'd1, 32'h44332211, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b0, 12'h084, 2'd2, 32'h0,        1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 32'h43424140, 2'd2},
        '{1'b0, 12'h084, 2'd1, 32'h0,        1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 32'h00004140, 2'd0},
        '{1'b0, 12'h084, 2'd0, 32'h0,        1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h00000040, 2'd0},
        '{1'b1, 12'h0AC, 2'd0, 32'h44332211, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b1, 12'h0B4, 2'd2, 32'h44332211, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0,        2'd1},
        '{1'b1, 12'h0B0, 2'd1, 32'h44332211, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0,        2'd0},
        '{1'b0, 12'h0B4, 2'd2, 32'h0,        1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 32'hB141B040, 2'd3},
        '{1'b0, 12'h0B4, 2'd1, 32'h0,        1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0000B040, 2'd0},
        '{1'b0, 12'h0B4, 2'd0, 32'h0,        1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 32'h00000040, 2'd0},
        '{1'b1, 12'h0E4, 2'd2, 32'h44332211, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b0, 12'h0E4, 2'd2, 32'h0,        1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b0, 12'h07C, 2'd2, 32'h0,        1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b1, 12'h060, 2'd0, 32'h44332211, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0,        2'd0},
        '{1'b0, 12'h010, 2'd1, 32'h0,        1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0,        2'd0},
        '{1'b1, 12'h060, 2'd2, 32'h44332211, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b1, 12'h1D4, 2'd1, 32'h44332211, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0},
        '{1'b0, 12'h1D7, 2'd0, 32'h0,        1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h00000040, 2'd1},
        '{1'b1, 12'h084, 2'd3, 32'h44332211, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0,        2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic          cpu_ready;
    logic          cpu_we = 1'b0;
    logic [11:0]   cpu_addr = '0;
    logic [1:0]    cpu_size = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_done, cpu_err;
    logic [31:0]   cpu_rdata;
    logic [NB-1:0] cfg_nand = 8'b1000_0011;
    logic [NB-1:0] cfg_wide = 8'b0000_0010;
    logic          dev_valid, dev_we, dev_cle, dev_ale;
    logic          dev_ready = 1'b0;
    logic [NB-1:0] dev_cs;
    logic [15:0]   dev_wdata;
    logic [15:0]   dev_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int stall_len = 0;
    int stall_cnt = 0;
    int rec_n = 0;
    logic [15:0]   rec_wd  [8];
    logic          rec_we  [8];
    logic          rec_cle [8];
    logic          rec_ale [8];
    logic [NB-1:0] rec_cs  [8];

    always #5 clk = ~clk;

    nba_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_err(cpu_err),
        .cpu_rdata(cpu_rdata), .cfg_nand(cfg_nand), .cfg_wide(cfg_wide),
        .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_we(dev_we),
        .dev_cle(dev_cle), .dev_ale(dev_ale), .dev_cs(dev_cs),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Device model: stalls stall_len cycles, then answers one cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                dev_ready = 1'b0;
                stall_cnt = 0;
            end else if (dev_ready) begin
                dev_ready = 1'b0;
            end else if (dev_valid) begin
                if (stall_cnt >= stall_len) begin
                    if (rec_n < 8) begin
                        rec_wd[rec_n]  = dev_wdata;
                        rec_we[rec_n]  = dev_we;
                        rec_cle[rec_n] = dev_cle;
                        rec_ale[rec_n] = dev_ale;
                        rec_cs[rec_n]  = dev_cs;
                    end
                    dev_rdata = {4'hB, 4'(rec_n), 4'h4, 4'(rec_n)};
                    dev_ready = 1'b1;
                    rec_n++;
                    stall_cnt = 0;
                end else begin
                    stall_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    function automatic logic [15:0] exp_wd(input vec_t v, input int i);
        if (v.wide) return (i == 0) ? v.wdata[15:0] : v.wdata[31:16];
        return {8'h00, v.wdata[i*8 +: 8]};
    endfunction

    function automatic string req_tag(input vec_t v);
        if (v.err) return "R5";
        if (v.ncyc == 0) begin
            if (v.addr >= 12'h0C0 && v.addr < 12'h0F0) return "R6";
            if (v.addr == 12'h060) return "R5";
            return "R4";
        end
        if (v.wide && v.size == 2'd0) return "R3";
        if (v.wide) return "R2";
        return "R1";
    endfunction

    task automatic run_access(input vec_t v, output logic got_err,
                              output logic [31:0] got_rd);
        int t;
        @(negedge clk);
        rec_n     = 0;
        stall_len = int'(v.stall);
        cpu_we    = v.we;
        cpu_addr  = v.addr;
        cpu_size  = v.size;
        cpu_wdata = v.wdata;
        cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        t = 0;
        while (!cpu_done && t < 1000) begin
            @(negedge clk);
            t++;
        end
        got_err = cpu_err;
        got_rd  = cpu_rdata;
    endtask

    initial begin
        logic        e;
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state after reset
        check(cpu_ready == 1'b1, "R9 cpu_ready after reset", 32'(cpu_ready), 32'd1);
        check(dev_valid == 1'b0, "R9 dev_valid after reset", 32'(dev_valid), 32'd0);
        check(cpu_done == 1'b0, "R9 cpu_done after reset", 32'(cpu_done), 32'd0);
        check(cpu_rdata == 32'd0, "R9 cpu_rdata after reset", cpu_rdata, 32'd0);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string tag;
            v   = VECS[k];
            tag = req_tag(v);
            run_access(v, e, rd);
            check(rec_n == int'(v.ncyc), {tag, " cycle count"}, 32'(rec_n), 32'(v.ncyc));
            check(e == v.err, {tag, " cpu_err"}, 32'(e), 32'(v.err));
            check(cpu_done == 1'b1, "R7 completion seen", 32'(cpu_done), 32'd1);
            if (!v.we)
                check(rd == v.rdata, {tag, " R8 read lanes"}, rd, v.rdata);
            for (int i = 0; i < int'(v.ncyc) && i < rec_n; i++) begin
                logic [NB-1:0] ecs;
                ecs = NB'(1) << ((v.addr - 12'h060) / 12'h030);
                check(rec_we[i] == v.we, {tag, " dev_we"}, 32'(rec_we[i]), 32'(v.we));
                check(rec_cle[i] == v.cle, "R4 dev_cle", 32'(rec_cle[i]), 32'(v.cle));
                check(rec_ale[i] == v.ale, "R4 dev_ale", 32'(rec_ale[i]), 32'(v.ale));
                check(rec_cs[i] == ecs, "R10 dev_cs", 32'(rec_cs[i]), 32'(ecs));
                if (v.we)
                    check(rec_wd[i] == exp_wd(v, i), {tag, " dev_wdata lane"},
                          32'(rec_wd[i]), 32'(exp_wd(v, i)));
            end
        end

        // R9 / R7: reset while a cycle is stalled abandons the transfer
        @(negedge clk);
        rec_n     = 0;
        stall_len = 1000;
        cpu_we    = 1'b0;
        cpu_addr  = 12'h084;
        cpu_size  = 2'd2;
        cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(dev_valid == 1'b1, "R7 stalled cycle held", 32'(dev_valid), 32'd1);
        check(cpu_ready == 1'b0, "R7 busy while stalled", 32'(cpu_ready), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check(dev_valid == 1'b0, "R9 reset drops dev_valid", 32'(dev_valid), 32'd0);
        check(cpu_ready == 1'b1, "R9 reset restores ready", 32'(cpu_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        run_access(VECS[3], e, rd);
        check(rd == 32'h43424140, "R8 read after abandoned transfer", rd, 32'h43424140);
        check(rec_n == 4, "R1 cycles after abandoned transfer", 32'(rec_n), 32'd4);

        summary();
        $finish;
    end

endmodule